// File: doc/BRIEF.md
# SIMT Branch Divergence Lane-Mask Sequencer

This block steers one warp of lanes that all receive the same instruction on the same clock edge. It keeps the warp's active-lane mask, which is loaded from a live-lane count when a warp is started. When that count is not a multiple of the warp width (the tail warp of a launch), the unused upper lanes stay off for the whole life of the warp. On each branch it splits the active lanes by a per-lane predicate. It runs the taken path with only the agreeing lanes enabled, then the other path with the remaining lanes, and restores the pre-branch mask when the paths rejoin.

Path bodies are given as instruction counts and are counted down one cycle per instruction. A path that no lane needs, or that has zero length, is skipped, so a branch on which all active lanes agree costs only the one path it takes. A branch may arrive while a path is running. The remaining count of the interrupted path is saved on a small mask stack, and that path resumes after the inner branch rejoins. A branch that would overflow the stack is dropped and latches an error flag.

Top module: `simt_div_seq`

## Requirements
- R1: A cycle with `warp_load` high sets `active_mask` so that lane i is on exactly when i < `warp_lanes` (all lanes on for counts of 32 or more). It empties the stack (`stack_depth` = 0), starts no path, and takes priority over a branch in the same cycle.
- R2: In every execute cycle `exec_valid` is 1 and `lane_en` equals `active_mask`. In every other cycle `lane_en` is 0.
- R3: An accepted branch cycle is not an execute cycle. It pushes one stack level. The taken mask is `br_pred` AND the active mask, and the else mask is NOT `br_pred` AND the active mask. The taken path runs first, for `br_len_taken` execute cycles.
- R4: When both paths run, exactly one idle cycle (`exec_valid` and `reconv_done` both 0) follows the taken path's last cycle. The else path then runs for `br_len_else` execute cycles.
- R5: A path whose mask is zero or whose length is zero is skipped with no cycles spent on it. A branch on which all active lanes agree adds no switch cycle.
- R6: Rejoining takes one cycle with `reconv_done` = 1 and `exec_valid` = 0, right after the last executed path cycle, or right after the branch cycle if both paths were skipped. Next cycle `active_mask` holds its pre-branch value and `stack_depth` is one lower.
- R7: A branch accepted while a path is running saves that path's remaining count. After the inner branch rejoins, the outer path runs its remaining cycles under the outer mask.
- R8: The stack holds 4 levels. A branch arriving at depth 4 is ignored: depth, mask and the running path are unchanged, and `stack_err` goes to 1.
- R9: `stack_err` stays 1 until reset. `warp_load` does not clear it.
- R10: After reset `active_mask` is 0, `stack_depth` is 0, and `stack_err`, `exec_valid` and `reconv_done` are 0.
- R11: No lane at or above the last loaded lane count is ever enabled in `lane_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_load | input | 1 | Start a warp with a fresh mask |
| warp_lanes | input | 6 | Number of live lanes in the warp being started |
| br_valid | input | 1 | Branch presented this cycle |
| br_pred | input | 32 | Per-lane branch outcome, 1 = taken |
| br_len_taken | input | 8 | Instruction count of the taken path |
| br_len_else | input | 8 | Instruction count of the else path |
| lane_en | output | 32 | Per-lane write enable for this cycle |
| exec_valid | output | 1 | An instruction issues this cycle |
| reconv_done | output | 1 | Paths rejoin this cycle |
| active_mask | output | 32 | Current active-lane mask |
| stack_depth | output | 3 | Occupied mask stack levels |
| stack_err | output | 1 | Sticky stack overflow flag |

## Verification
The bench builds the block with its default parameters: 32 lanes, a 4-level stack and 8-bit path counts. At these values a tail warp of 4 lanes, saturation of an oversized lane count, and overflow after four nested branches can all be reached within a few dozen cycles. Table-driven branches cover divergent, uniform, empty-path and zero-length cases, with cycle counts checked against the path lengths. Directed sequences trace a two-level nest cycle by cycle and push the stack past its limit.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

  // What the sequencer does in a given cycle, in priority order.
  typedef enum logic [2:0] {
    STEP_IDLE   = 3'd0,
    STEP_LOAD   = 3'd1,
    STEP_BRANCH = 3'd2,
    STEP_EXEC   = 3'd3,
    STEP_SWITCH = 3'd4,
    STEP_JOIN   = 3'd5
  } seq_step_e;

endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen #(
  parameter int LANES = 32,
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] lane_cnt,
  output logic [LANES-1:0] mask
);

  // Lane i lives when the count exceeds i; oversized counts saturate.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (lane_cnt > CNT_W'(i));
  end

endmodule

// File: rtl/branch_split.sv
module branch_split #(
  parameter int LANES = 32,
  parameter int LEN_W = 8
) (
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] pred,
  input  logic [LEN_W-1:0] len_taken,
  input  logic [LEN_W-1:0] len_else,
  output logic [LANES-1:0] mask_taken,
  output logic [LANES-1:0] mask_else,
  output logic             run_taken,
  output logic             run_else
);

  assign mask_taken = pred & active;
  assign mask_else  = ~pred & active;
  // A path is worth running only if some lane needs it and it has a body.
  assign run_taken  = (|mask_taken) && (len_taken != '0);
  assign run_else   = (|mask_else) && (len_else != '0);

endmodule

// File: rtl/mask_stack.sv
module mask_stack #(
  parameter int W        = 81,
  parameter int DEPTH    = 4,
  parameter int FLAG_BIT = 0,
  localparam int SP_W    = $clog2(DEPTH + 1),
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            push,
  input  logic [W-1:0]    push_data,
  input  logic            pop,
  input  logic            clr_flag,
  output logic [W-1:0]    top_data,
  output logic [SP_W-1:0] depth,
  output logic            full
);

  logic [SP_W-1:0]  sp_q, sp_d;
  logic             sp_en;
  logic [W-1:0]     ent_all [DEPTH];
  logic [IDX_W-1:0] top_idx;

  always_comb begin
    sp_d = sp_q;
    if (clear)     sp_d = '0;
    else if (push) sp_d = sp_q + SP_W'(1);
    else if (pop)  sp_d = sp_q - SP_W'(1);
  end

  assign sp_en = clear | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] ent_q, ent_d;
    logic         ent_en;

    always_comb begin
      ent_d  = ent_q;
      ent_en = 1'b0;
      if (push && !clear && sp_q == SP_W'(i)) begin
        ent_d  = push_data;
        ent_en = 1'b1;
      end else if (clr_flag && !clear && sp_q == SP_W'(i + 1)) begin
        ent_d[FLAG_BIT] = 1'b0;
        ent_en          = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (ent_en) ent_q <= ent_d;
    end

    assign ent_all[i] = ent_q;
  end

  assign top_idx  = (sp_q == '0) ? '0 : IDX_W'(sp_q - SP_W'(1));
  assign top_data = ent_all[top_idx];
  assign depth    = sp_q;
  assign full     = (sp_q == SP_W'(DEPTH));

endmodule

// File: rtl/simt_div_seq.sv
module simt_div_seq
  import simt_div_pkg::*;
#(
  parameter int  LANES = 32,
  parameter int  DEPTH = 4,
  parameter int  LEN_W = 8,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warp_load,
  input  logic [CNT_W-1:0] warp_lanes,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_pred,
  input  logic [LEN_W-1:0] br_len_taken,
  input  logic [LEN_W-1:0] br_len_else,
  output logic [LANES-1:0] lane_en,
  output logic             exec_valid,
  output logic             reconv_done,
  output logic [LANES-1:0] active_mask,
  output logic [SP_W-1:0]  stack_depth,
  output logic             stack_err
);

  // Frame layout: {restore mask, else mask, else length, resume count, else pending}
  localparam int FW       = 2 * LANES + 2 * LEN_W + 1;
  localparam int PEND_B   = 0;
  localparam int RES_LO   = 1;
  localparam int ELEN_LO  = RES_LO + LEN_W;
  localparam int EMASK_LO = ELEN_LO + LEN_W;
  localparam int REST_LO  = EMASK_LO + LANES;

  logic [LANES-1:0] act_q, act_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             err_q, err_d;
  logic             upd_en;

  logic [LANES-1:0] load_mask;
  logic [LANES-1:0] mask_taken, mask_else;
  logic             run_taken, run_else;

  logic             stk_clear, stk_push, stk_pop, stk_clr;
  logic [FW-1:0]    push_frame, top_frame;
  logic [SP_W-1:0]  stk_depth;
  logic             stk_full;
  seq_step_e        step;

  lane_mask_gen #(.LANES(LANES), .CNT_W(CNT_W)) u_mask_gen (
    .lane_cnt (warp_lanes),
    .mask     (load_mask)
  );

  branch_split #(.LANES(LANES), .LEN_W(LEN_W)) u_split (
    .active     (act_q),
    .pred       (br_pred),
    .len_taken  (br_len_taken),
    .len_else   (br_len_else),
    .mask_taken (mask_taken),
    .mask_else  (mask_else),
    .run_taken  (run_taken),
    .run_else   (run_else)
  );

  mask_stack #(.W(FW), .DEPTH(DEPTH), .FLAG_BIT(PEND_B)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (stk_clear),
    .push      (stk_push),
    .push_data (push_frame),
    .pop       (stk_pop),
    .clr_flag  (stk_clr),
    .top_data  (top_frame),
    .depth     (stk_depth),
    .full      (stk_full)
  );

  assign push_frame = {act_q, mask_else, br_len_else, rem_q, run_taken & run_else};

  // Choose this cycle's action.
  always_comb begin
    step = STEP_IDLE;
    if (warp_load)                 step = STEP_LOAD;
    else if (br_valid && !stk_full) step = STEP_BRANCH;
    else if (rem_q != '0)          step = STEP_EXEC;
    else if (stk_depth != '0)      step = top_frame[PEND_B] ? STEP_SWITCH : STEP_JOIN;
  end

  // Next-state of mask, remaining count and error flag.
  always_comb begin
    act_d     = act_q;
    rem_d     = rem_q;
    err_d     = err_q | (br_valid && !warp_load && stk_full);
    stk_clear = 1'b0;
    stk_push  = 1'b0;
    stk_pop   = 1'b0;
    stk_clr   = 1'b0;
    unique case (step)
      STEP_LOAD: begin
        act_d     = load_mask;
        rem_d     = '0;
        stk_clear = 1'b1;
      end
      STEP_BRANCH: begin
        stk_push = 1'b1;
        if (run_taken) begin
          act_d = mask_taken;
          rem_d = br_len_taken;
        end else if (run_else) begin
          act_d = mask_else;
          rem_d = br_len_else;
        end else begin
          rem_d = '0;
        end
      end
      STEP_EXEC: rem_d = rem_q - LEN_W'(1);
      STEP_SWITCH: begin
        act_d   = top_frame[EMASK_LO +: LANES];
        rem_d   = top_frame[ELEN_LO +: LEN_W];
        stk_clr = 1'b1;
      end
      STEP_JOIN: begin
        act_d   = top_frame[REST_LO +: LANES];
        rem_d   = top_frame[RES_LO +: LEN_W];
        stk_pop = 1'b1;
      end
      default: ;
    endcase
  end

  assign upd_en = (step != STEP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      rem_q <= '0;
    end else if (upd_en) begin
      act_q <= act_d;
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_q <= 1'b0;
    else if (err_d) err_q <= err_d;
  end

  assign exec_valid  = (step == STEP_EXEC);
  assign reconv_done = (step == STEP_JOIN);
  assign lane_en     = exec_valid ? act_q : '0;
  assign active_mask = act_q;
  assign stack_depth = stk_depth;
  assign stack_err   = err_q;

endmodule

// File: rtl/simt_div_seq_chk.sv
module simt_div_seq_chk #(
  parameter int  LANES = 32,
  parameter int  DEPTH = 4,
  parameter int  LEN_W = 8,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             warp_load,
  input logic [CNT_W-1:0] warp_lanes,
  input logic             br_valid,
  input logic [LANES-1:0] lane_en,
  input logic             exec_valid,
  input logic             reconv_done,
  input logic [SP_W-1:0]  stack_depth,
  input logic             stack_err
);

  // Lanes permitted by the most recent warp start.
  logic [LANES-1:0] live_q;
  logic [LANES-1:0] live_new;

  always_comb begin
    if (int'(warp_lanes) >= LANES) live_new = '1;
    else live_new = (LANES'(1) << warp_lanes) - LANES'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         live_q <= '0;
    else if (warp_load) live_q <= live_new;
  end

  assert_no_stray_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en & ~live_q) == '0)
    else $error("stray lane enabled");

  assert_idle_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_valid |-> (lane_en == '0))
    else $error("lanes enabled outside execute");

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err)
    else $error("error flag dropped");

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= SP_W'(DEPTH))
    else $error("depth over limit");

  assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !warp_load && stack_depth == SP_W'(DEPTH)) |=>
      (stack_err && stack_depth == SP_W'(DEPTH)))
    else $error("overflow not handled");

  assert_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !warp_load && stack_depth < SP_W'(DEPTH)) |=>
      (stack_depth == $past(stack_depth) + SP_W'(1)))
    else $error("branch did not push");

  assert_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reconv_done |=> (stack_depth == $past(stack_depth) - SP_W'(1)))
    else $error("rejoin did not pop");

  assert_join_not_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reconv_done && exec_valid))
    else $error("rejoin during execute");

  assert_load_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    warp_load |=> (stack_depth == '0))
    else $error("load left stack occupied");

endmodule

bind simt_div_seq simt_div_seq_chk #(.LANES(LANES), .DEPTH(DEPTH), .LEN_W(LEN_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .warp_load   (warp_load),
  .warp_lanes  (warp_lanes),
  .br_valid    (br_valid),
  .lane_en     (lane_en),
  .exec_valid  (exec_valid),
  .reconv_done (reconv_done),
  .stack_depth (stack_depth),
  .stack_err   (stack_err)
);

// File: tb/simt_div_seq_tb_top.sv
`timescale 1ns/1ps
module simt_div_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        warp_load;
  logic [5:0]  warp_lanes;
  logic        br_valid;
  logic [31:0] br_pred;
  logic [7:0]  br_len_taken;
  logic [7:0]  br_len_else;
  logic [31:0] lane_en;
  logic        exec_valid;
  logic        reconv_done;
  logic [31:0] active_mask;
  logic [2:0]  stack_depth;
  logic        stack_err;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  simt_div_seq dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .warp_load    (warp_load),
    .warp_lanes   (warp_lanes),
    .br_valid     (br_valid),
    .br_pred      (br_pred),
    .br_len_taken (br_len_taken),
    .br_len_else  (br_len_else),
    .lane_en      (lane_en),
    .exec_valid   (exec_valid),
    .reconv_done  (reconv_done),
    .active_mask  (active_mask),
    .stack_depth  (stack_depth),
    .stack_err    (stack_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {lane count, predicate, taken length, else length}
  localparam int NV = 8;
  localparam logic [53:0] VEC [NV] = '{
    {6'd32, 32'h0000FFFF, 8'd3, 8'd2},
    {6'd32, 32'hFFFFFFFF, 8'd4, 8'd6},
    {6'd32, 32'h00000000, 8'd4, 8'd6},
    {6'd4,  32'hFFFFFFF0, 8'd2, 8'd3},
    {6'd4,  32'h00000005, 8'd2, 8'd2},
    {6'd17, 32'h00010001, 8'd1, 8'd1},
    {6'd32, 32'hAAAAAAAA, 8'd0, 8'd3},
    {6'd40, 32'h00000001, 8'd1, 8'd1}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] live_mask(input int n);
    if (n >= 32) return 32'hFFFFFFFF;
    return (32'h1 << n) - 32'h1;
  endfunction

  task automatic load_warp(input int n);
    warp_load  = 1'b1;
    warp_lanes = 6'(n);
    @(negedge clk);
    warp_load  = 1'b0;
  endtask

  task automatic set_br(input logic [31:0] p, input logic [7:0] la, input logic [7:0] lb);
    br_valid     = 1'b1;
    br_pred      = p;
    br_len_taken = la;
    br_len_else  = lb;
  endtask

  // Check this cycle's outputs, then move to the next negedge.
  task automatic step_chk(input string req, input bit e_exec,
                          input logic [31:0] e_lane, input bit e_done);
    #2;
    chk(req, "exec_valid", 64'(exec_valid), 64'(e_exec));
    chk(req, "lane_en", 64'(lane_en), 64'(e_lane));
    chk(req, "reconv_done", 64'(reconv_done), 64'(e_done));
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; warp_load = 1'b0; warp_lanes = '0;
    br_valid = 1'b0; br_pred = '0; br_len_taken = '0; br_len_else = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "active_mask", 64'(active_mask), 64'h0);
    chk("R10", "stack_depth", 64'(stack_depth), 64'h0);
    chk("R10", "stack_err", 64'(stack_err), 64'h0);
    chk("R10", "exec/done", 64'({exec_valid, reconv_done}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table-driven branches: R1, R2, R3, R4, R5, R6, R11
    for (int v = 0; v < NV; v++) begin
      int n, cyc, ca, cb, bad, stray;
      logic [31:0] lm, ma, mb, first;
      bit ra, rb, got_first, got_done;
      logic [7:0] la, lb;
      n  = int'(VEC[v][53:48]);
      lm = live_mask(n);
      la = VEC[v][15:8];
      lb = VEC[v][7:0];
      ma = VEC[v][47:16] & lm;
      mb = ~VEC[v][47:16] & lm;
      ra = (ma != 0) && (la != 0);
      rb = (mb != 0) && (lb != 0);
      load_warp(n);
      chk("R1", "loaded mask", 64'(active_mask), 64'(lm));
      chk("R1", "depth after load", 64'(stack_depth), 64'h0);
      set_br(VEC[v][47:16], la, lb);
      #2;
      chk("R3", "branch cycle exec", 64'(exec_valid), 64'h0);
      @(negedge clk);
      br_valid = 1'b0;
      cyc = 1; ca = 0; cb = 0; bad = 0; stray = 0;
      got_first = 0; got_done = 0; first = '0;
      while (cyc < 100 && !got_done) begin
        #2;
        if (exec_valid) begin
          if (!got_first) begin first = lane_en; got_first = 1; end
          if (ra && lane_en == ma) ca++;
          else if (rb && lane_en == mb) cb++;
          else bad++;
          if ((lane_en & ~lm) != 0) stray++;
          if (lane_en != active_mask) bad++;
        end
        if (reconv_done) got_done = 1;
        else begin
          @(negedge clk);
          cyc++;
        end
      end
      chk("R3", "taken cycles", 64'(ca), 64'(ra ? int'(la) : 0));
      chk("R4", "else cycles", 64'(cb), 64'(rb ? int'(lb) : 0));
      chk("R2", "unexpected lane_en", 64'(bad), 64'h0);
      chk("R11", "stray lanes", 64'(stray), 64'h0);
      if (ra) chk("R3", "taken path first", 64'(first), 64'(ma));
      chk("R5", "rejoin cycle index", 64'(cyc),
          64'(1 + ca + cb + ((ra && rb) ? 1 : 0)));
      @(negedge clk);
      chk("R6", "restored mask", 64'(active_mask), 64'(lm));
      chk("R6", "depth after rejoin", 64'(stack_depth), 64'h0);
    end

    // R7: nested divergence traced cycle by cycle
    load_warp(32);
    set_br(32'h0000FFFF, 8'd3, 8'd2);
    step_chk("R3", 0, 32'h0, 0);
    set_br(32'h000000FF, 8'd1, 8'd1);
    step_chk("R7", 0, 32'h0, 0);
    br_valid = 1'b0;
    chk("R7", "inner depth", 64'(stack_depth), 64'h2);
    step_chk("R7", 1, 32'h000000FF, 0);
    step_chk("R4", 0, 32'h0, 0);
    step_chk("R4", 1, 32'h0000FF00, 0);
    step_chk("R6", 0, 32'h0, 1);
    chk("R7", "outer mask back", 64'(active_mask), 64'h0000FFFF);
    step_chk("R7", 1, 32'h0000FFFF, 0);
    step_chk("R7", 1, 32'h0000FFFF, 0);
    step_chk("R7", 1, 32'h0000FFFF, 0);
    step_chk("R4", 0, 32'h0, 0);
    step_chk("R4", 1, 32'hFFFF0000, 0);
    step_chk("R4", 1, 32'hFFFF0000, 0);
    step_chk("R6", 0, 32'h0, 1);
    chk("R6", "full mask back", 64'(active_mask), 64'hFFFFFFFF);
    chk("R6", "depth zero", 64'(stack_depth), 64'h0);

    // R1: load wins over a branch in the same cycle
    set_br(32'h0000000F, 8'd2, 8'd2);
    warp_load = 1'b1; warp_lanes = 6'd8;
    @(negedge clk);
    warp_load = 1'b0; br_valid = 1'b0;
    chk("R1", "depth with load+branch", 64'(stack_depth), 64'h0);
    chk("R1", "mask with load+branch", 64'(active_mask), 64'h000000FF);

    // R8: overflow on the fifth nested branch
    load_warp(32);
    for (int k = 0; k < 4; k++) begin
      set_br(32'hFFFFFFFF, 8'd5, 8'd0);
      @(negedge clk);
    end
    chk("R8", "depth full", 64'(stack_depth), 64'h4);
    chk("R8", "err before overflow", 64'(stack_err), 64'h0);
    set_br(32'h0000FFFF, 8'd1, 8'd1);
    #2;
    chk("R8", "path continues", 64'(exec_valid), 64'h1);
    @(negedge clk);
    br_valid = 1'b0;
    chk("R8", "depth unchanged", 64'(stack_depth), 64'h4);
    chk("R8", "mask unchanged", 64'(active_mask), 64'hFFFFFFFF);
    chk("R8", "err set", 64'(stack_err), 64'h1);

    // R9: error survives a load and a few idle cycles
    load_warp(16);
    repeat (3) @(negedge clk);
    chk("R9", "err after load", 64'(stack_err), 64'h1);

    // R10: reset clears the flag and the state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", "err after reset", 64'(stack_err), 64'h0);
    chk("R10", "mask after reset", 64'(active_mask), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule